// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a host read a serial NOR flash as if it were ordinary memory. The host first writes a 32-bit command template. The template gives the read opcode, the number of address bytes, the number of dummy bytes and whether the data phase uses one lane or several. A valid template arms the engine, and the `init_done` status output rises. After that, each read request on the bus becomes one complete flash frame:

- chip select goes low;
- the opcode and the request offset are shifted out serially on lane 0;
- the dummy clocks follow;
- four data bytes are clocked in on one, two or four lanes;
- the bytes are returned on the response channel as one 32-bit little-endian word.

The engine leaves memory mode only through a soft reset pulse. The pulse clears the status flag and stops any frame in progress. The host must then write a new template before it can issue reads again.

Both the request side and the response side use valid/ready handshakes:

- **Request side.** A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low while the engine is not armed, while a frame is running, and while a response has not yet been taken. A requester can therefore hold `req_valid` high for as long as it needs to.
- **Response side.** Once `rsp_valid` is high, it stays high and `rsp_data` stays unchanged until the cycle in which `rsp_ready` is high. No new request is accepted before that cycle.

Top module: `flash_window_reader`

## Requirements
- R1: After reset, `init_done`, `req_ready`, `rsp_valid`, `sck` and `io_oe` are all low, and `cs_n` is high.
- R2: A template write is accepted only if its frame code (bits 23:21) is in 2..5 and its lane code (bits 20:19) is 0 or 1. An accepted write raises `init_done` on the next cycle. A rejected write leaves `init_done` low.
- R3: A template write while `init_done` is high has no effect. Later frames keep the opcode and address width of the earlier template.
- R4: While `init_done` is low, `req_ready` stays low and no frame starts. A request that is held pending is served once the engine is armed.
- R5: A frame starts with `cs_n` falling. Then, on `io_out[0]`, MSB first, come: the opcode (template bits 31:24), then the offset truncated to (frame code − 1) bytes, then 8 × (bits 18:16) dummy clocks. The clock idles low, and the flash samples on the rising edge.
- R6: With lane code 0, data is read from `io_in[1]`, one bit per clock, MSB first.
- R7: With lane code 1 and `lane_dual` = 1, each clock carries two bits on `io_in[1:0]`, with `io_in[1]` as the higher bit. With `lane_dual` = 0, each clock carries one nibble on `io_in[3:0]`, with the high nibble first.
- R8: Four consecutive bytes are fetched per request. The first byte received lands in `rsp_data[7:0]` and the last in `rsp_data[31:24]`.
- R9: `rsp_valid` stays high with stable `rsp_data` until `rsp_ready`. `req_ready` is low while a response is pending.
- R10: A `soft_rst` pulse clears `init_done`, raises `cs_n` on the next cycle and drops any frame and response in flight. A new template write then re-arms the engine.
- R11: `io_oe` is 4'b0001 during the opcode, address and dummy clocks, and 4'b0000 during the data clocks and while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Pulse: leave memory mode, abort frame |
| cfg_wr | input | 1 | Template write strobe |
| cfg_word | input | 32 | Command template |
| lane_dual | input | 1 | Wide data: 1 = two lanes, 0 = four lanes |
| init_done | output | 1 | Engine armed and serving reads |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with valid |
| req_addr | input | OFF_W | Window offset of the read |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | DATA_W | Read data, little-endian |
| sck | output | 1 | Flash clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Flash lane outputs |
| io_oe | output | 4 | Flash lane output enables |
| io_in | input | 4 | Flash lane inputs |

## Verification
The bench runs a table of templates that covers every address width, zero to seven dummy bytes and all three lane modes. A behavioural flash model in the bench decodes the header. A wrong dummy count shifts the data stream and corrupts the returned word. A swapped lane or nibble order scrambles the bits, and a missing truncation shows up as a wrong captured address. Directed tests check the following:

- a request held back before arming;
- rejected templates and a template rewrite while armed;
- a response held under back-pressure;
- a soft reset in the middle of a frame.

A design that went wrong on any of these would serve a read too early, switch its opcode without warning, drop or change a pending word, or leave the chip selected.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [2:0]  frame;
    logic [1:0]  field;
    logic [2:0]  dummy;
    logic [15:0] low;
  } tmpl_t;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  function automatic int lane_shift(lane_e l);
    case (l)
      LANE_X2: return 1;
      LANE_X4: return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/fwr_cfg_reg.sv
module fwr_cfg_reg
  import fwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_word,
  output logic        armed,
  output logic [7:0]  opcode,
  output logic [2:0]  abytes,
  output logic [2:0]  dbytes,
  output logic        wide
);
  tmpl_t w;
  logic  legal;
  logic  unused_low;

  assign w          = tmpl_t'(cfg_word);
  assign unused_low = ^w.low;
  assign legal      = (w.frame >= 3'd2) && (w.frame <= 3'd5) && (w.field <= 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      opcode <= '0;
      abytes <= 3'd1;
      dbytes <= '0;
      wide   <= 1'b0;
    end else if (soft_rst) begin
      armed <= 1'b0;
    end else if (cfg_wr && !armed && legal) begin
      armed  <= 1'b1;
      opcode <= w.opcode;
      abytes <= w.frame - 3'd1;
      dbytes <= w.dummy;
      wide   <= w.field[0];
    end
  end
endmodule

// File: rtl/fwr_frame_seq.sv
module fwr_frame_seq
  import fwr_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [2:0]       abytes,
  input  logic [2:0]       dbytes,
  input  lane_e            lanes,
  input  logic [OFF_W-1:0] offset,
  output lane_e            lanes_q,
  output logic             idle,
  output logic             done,
  output logic             sample,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe
);
  localparam int HDR_W   = 8 + 32;
  localparam int MAX_CLK = 8 + 32 + 56 + DATA_W;
  localparam int CNT_W   = $clog2(MAX_CLK + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_END} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q, hdr_len_q, last_q;
  logic [CNT_W-1:0] hdr_len_d, data_len_d;
  logic [HDR_W-1:0] hdr_q;
  logic [31:0]      off32, aligned;
  logic             active, in_hdr;

  always_comb begin
    off32 = 32'(offset);
    case (abytes)
      3'd1:    aligned = {off32[7:0], 24'h0};
      3'd2:    aligned = {off32[15:0], 16'h0};
      3'd3:    aligned = {off32[23:0], 8'h0};
      default: aligned = off32;
    endcase
    hdr_len_d  = CNT_W'(32'd8 + 32'(abytes) * 32'd8 + 32'(dbytes) * 32'd8);
    data_len_d = CNT_W'(DATA_W >> lane_shift(lanes));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      hdr_len_q <= '0;
      last_q    <= '0;
      hdr_q     <= '0;
      lanes_q   <= LANE_X1;
    end else if (abort) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q      <= S_LOW;
          cnt_q     <= '0;
          hdr_len_q <= hdr_len_d;
          last_q    <= hdr_len_d + data_len_d - CNT_W'(1);
          hdr_q     <= {opcode, aligned};
          lanes_q   <= lanes;
        end
        S_LOW: st_q <= S_HIGH;
        S_HIGH: begin
          if (cnt_q == last_q) begin
            st_q <= S_END;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
            st_q  <= S_LOW;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign active = (st_q == S_LOW) || (st_q == S_HIGH);
  assign in_hdr = cnt_q < hdr_len_q;
  assign idle   = (st_q == S_IDLE);
  assign done   = (st_q == S_END);
  assign sck    = (st_q == S_HIGH);
  assign cs_n   = !active;
  assign sample = (st_q == S_LOW) && !in_hdr;
  assign io_oe  = (active && in_hdr) ? 4'b0001 : 4'b0000;
  assign io_out = {3'b000, hdr_q[HDR_W-1] & active & in_hdr};
endmodule

// File: rtl/fwr_rx_assemble.sv
module fwr_rx_assemble
  import fwr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  lane_e             lanes,
  input  logic [3:0]        io_in,
  output logic [DATA_W-1:0] word
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (sample) begin
      case (lanes)
        LANE_X2: acc_q <= {acc_q[DATA_W-3:0], io_in[1:0]};
        LANE_X4: acc_q <= {acc_q[DATA_W-5:0], io_in};
        default: acc_q <= {acc_q[DATA_W-2:0], io_in[1]};
      endcase
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_swap
    assign word[8*g +: 8] = acc_q[DATA_W-8-8*g +: 8];
  end
endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader
  import fwr_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_word,
  input  logic              lane_dual,
  output logic              init_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  logic              armed, wide, seq_idle, seq_done, sample, start;
  logic [7:0]        opcode;
  logic [2:0]        abytes, dbytes;
  lane_e             lanes_d, lanes_q;
  logic [DATA_W-1:0] word;

  fwr_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .cfg_wr   (cfg_wr),
    .cfg_word (cfg_word),
    .armed    (armed),
    .opcode   (opcode),
    .abytes   (abytes),
    .dbytes   (dbytes),
    .wide     (wide)
  );

  assign lanes_d   = !wide ? LANE_X1 : (lane_dual ? LANE_X2 : LANE_X4);
  assign init_done = armed;
  assign req_ready = armed && seq_idle && !rsp_valid;
  assign start     = req_valid && req_ready;

  fwr_frame_seq #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (soft_rst),
    .start   (start),
    .opcode  (opcode),
    .abytes  (abytes),
    .dbytes  (dbytes),
    .lanes   (lanes_d),
    .offset  (req_addr),
    .lanes_q (lanes_q),
    .idle    (seq_idle),
    .done    (seq_done),
    .sample  (sample),
    .sck     (sck),
    .cs_n    (cs_n),
    .io_out  (io_out),
    .io_oe   (io_oe)
  );

  fwr_rx_assemble #(.DATA_W(DATA_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .sample (sample),
    .lanes  (lanes_q),
    .io_in  (io_in),
    .word   (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (soft_rst) begin
      rsp_valid <= 1'b0;
    end else if (seq_done) begin
      rsp_valid <= 1'b1;
      rsp_data  <= word;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fwr_checker.sv
module fwr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              cfg_wr,
  input logic              init_done,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              sck,
  input logic              cs_n,
  input logic [3:0]        io_oe
);
  a_r2_arm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cfg_wr));

  a_r4_no_accept_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);

  a_r5_clock_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r9_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  a_r10_reset_exits: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!init_done && cs_n && !rsp_valid));

  a_r11_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  a_r11_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(io_oe) <= 1);
endmodule

bind flash_window_reader fwr_checker #(.DATA_W(DATA_W)) u_fwr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .cfg_wr    (cfg_wr),
  .init_done (init_done),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .sck       (sck),
  .cs_n      (cs_n),
  .io_oe     (io_oe)
);

// File: tb/test_flash_window_reader.sv
`timescale 1ns/1ps
module test_flash_window_reader;
  localparam int OFF_W  = 32;
  localparam int DATA_W = 32;
  localparam int NV     = 8;
  // {field[48:47], dual[46], abytes[45:43], dbytes[42:40], opcode[39:32], offset[31:0]}
  localparam logic [48:0] VEC [NV] = '{
    {2'd0, 1'b0, 3'd3, 3'd0, 8'h03, 32'h0012_3456},
    {2'd0, 1'b0, 3'd3, 3'd1, 8'h0B, 32'h7FAB_CDEF},
    {2'd1, 1'b1, 3'd3, 3'd1, 8'h3B, 32'h0000_0FF0},
    {2'd1, 1'b0, 3'd3, 3'd3, 8'h6B, 32'h0000_1FFC},
    {2'd0, 1'b0, 3'd1, 3'd0, 8'h03, 32'h0000_12A7},
    {2'd1, 1'b0, 3'd4, 3'd2, 8'hEC, 32'hDEAD_BEEF},
    {2'd1, 1'b1, 3'd2, 3'd0, 8'hBB, 32'h0012_3457},
    {2'd0, 1'b0, 3'd4, 3'd7, 8'h0C, 32'h8000_0001}
  };

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, cfg_wr = 1'b0;
  logic lane_dual = 1'b0, req_valid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] cfg_word = '0, req_addr = '0;
  logic init_done, req_ready, rsp_valid, sck, cs_n;
  logic [31:0] rsp_data;
  logic [3:0] io_out, io_oe;
  logic [3:0] m_io = 4'hF;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_window_reader #(.OFF_W(OFF_W), .DATA_W(DATA_W)) i_flash_window_reader (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_word(cfg_word), .lane_dual(lane_dual), .init_done(init_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(m_io)
  );

  function automatic logic [7:0] memb(input logic [31:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] amask(input logic [31:0] a, input int ab);
    return (ab >= 4) ? a : (a & ((32'h1 << (8 * ab)) - 32'h1));
  endfunction

  // behavioural flash model
  int m_ab = 3, m_hdr = 32, m_lanes = 1;
  int m_edges = 0, m_sent = 0, m_frames = 0, oe_bad = 0;
  logic [7:0]  m_op = '0;
  logic [31:0] m_addr = '0, m_stream = '0;

  always @(negedge cs_n) begin
    m_edges = 0; m_sent = 0; m_op = '0; m_addr = '0; m_frames++;
  end

  always @(posedge sck) if (!cs_n) begin
    if (m_edges < m_hdr) begin
      if (io_oe !== 4'b0001) oe_bad++;
    end else if (io_oe !== 4'b0000) oe_bad++;
    if (m_edges < 8) m_op = {m_op[6:0], io_out[0]};
    else if (m_edges < 8 + 8 * m_ab) m_addr = {m_addr[30:0], io_out[0]};
    m_edges++;
  end

  always @(negedge sck) if (!cs_n && m_edges >= m_hdr && m_sent < 32 / m_lanes) begin
    logic [31:0] t;
    if (m_sent == 0)
      m_stream = {memb(m_addr), memb(m_addr + 1), memb(m_addr + 2), memb(m_addr + 3)};
    t = m_stream << (m_sent * m_lanes);
    case (m_lanes)
      1: m_io = {2'b11, t[31], 1'b1};
      2: m_io = {2'b11, t[31:30]};
      default: m_io = t[31:28];
    endcase
    m_sent++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic issue(input logic [31:0] off);
    req_addr = off; req_valid = 1'b1;
    @(negedge clk);
    while (cs_n) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(output logic [31:0] d);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
  endtask

  task automatic set_model(input int ab, input int db, input int field, input bit dual);
    m_ab = ab; m_hdr = 8 + 8 * ab + 8 * db;
    m_lanes = (field == 0) ? 1 : (dual ? 2 : 4);
  endtask

  task automatic run_read(input int field, input bit dual, input int ab, input int db,
                          input logic [7:0] op, input logic [31:0] off, input string tag);
    logic [31:0] d, ea, exp;
    pulse_reset();
    lane_dual = dual;
    set_model(ab, db, field, dual);
    cfg_write({op, 3'(ab + 1), 2'(field), 3'(db), 16'h0});
    issue(off);
    collect(d);
    ea  = amask(off, ab);
    exp = {memb(ea + 3), memb(ea + 2), memb(ea + 1), memb(ea)};
    check(d == exp, tag, d, exp, "R8 read word");
    check(m_op == op, "R5", {24'h0, m_op}, {24'h0, op}, "opcode");
    check(m_addr == ea, "R5", m_addr, ea, "address");
  endtask

  initial begin
    logic [31:0] d, d0, ea;
    bit stray;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(init_done == 1'b0, "R1", 32'(init_done), 0, "init_done");
    check(cs_n == 1'b1 && sck == 1'b0, "R1", {30'h0, cs_n, sck}, 32'h2, "cs_n/sck");
    check(req_ready == 1'b0 && rsp_valid == 1'b0, "R1", {30'h0, req_ready, rsp_valid}, 0, "handshakes");
    check(io_oe == 4'h0, "R1", 32'(io_oe), 0, "io_oe");

    // R4 request held off before arming
    set_model(3, 0, 0, 1'b0);
    req_addr = 32'h0000_0100; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    check(req_ready == 1'b0, "R4", 32'(req_ready), 0, "ready before arm");
    check(m_frames == 0, "R4", 32'(m_frames), 0, "frames before arm");

    // R2 rejected templates
    cfg_write({8'h03, 3'd1, 2'd0, 3'd0, 16'h0});
    check(init_done == 1'b0, "R2", 32'(init_done), 0, "frame code 1 rejected");
    cfg_write({8'h03, 3'd6, 2'd0, 3'd0, 16'h0});
    check(init_done == 1'b0, "R2", 32'(init_done), 0, "frame code 6 rejected");
    cfg_write({8'h03, 3'd4, 2'd2, 3'd0, 16'h0});
    check(init_done == 1'b0, "R2", 32'(init_done), 0, "lane code 2 rejected");
    cfg_write({8'h03, 3'd4, 2'd0, 3'd0, 16'h0});
    check(init_done == 1'b1, "R2", 32'(init_done), 1, "legal template arms");

    // R4 pending request now served
    while (cs_n) @(negedge clk);
    req_valid = 1'b0;
    collect(d);
    check(d == {memb(32'h103), memb(32'h102), memb(32'h101), memb(32'h100)}, "R4", d,
          {memb(32'h103), memb(32'h102), memb(32'h101), memb(32'h100)}, "held request");
    check(m_frames == 1, "R4", 32'(m_frames), 1, "one frame");

    // vector table: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      run_read(int'(v[48:47]), v[46], int'(v[45:43]), int'(v[42:40]), v[39:32], v[31:0],
               (v[48:47] == 2'd0) ? "R6" : "R7");
    end

    // R3 template write while armed is ignored (armed: op 0C, 4 address bytes)
    cfg_write({8'h3B, 3'd4, 2'd1, 3'd1, 16'h0});
    issue(32'h0000_0040);
    collect(d);
    check(m_op == 8'h0C, "R3", {24'h0, m_op}, 32'h0C, "opcode kept");
    check(m_addr == 32'h40, "R3", m_addr, 32'h40, "address width kept");

    // R9 response held under back-pressure
    issue(32'h0000_0200);
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_data;
    req_valid = 1'b1; req_addr = 32'h300;
    repeat (6) @(negedge clk);
    check(rsp_valid == 1'b1 && rsp_data == d0, "R9", rsp_data, d0, "held word");
    check(req_ready == 1'b0 && cs_n == 1'b1, "R9", {30'h0, req_ready, cs_n}, 1, "no accept while pending");
    req_valid = 1'b0;
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    ea = 32'h200;
    check(d0 == {memb(ea + 3), memb(ea + 2), memb(ea + 1), memb(ea)}, "R9", d0,
          {memb(ea + 3), memb(ea + 2), memb(ea + 1), memb(ea)}, "word value");

    // R10 soft reset mid-frame
    issue(32'h0000_0500);
    repeat (20) @(negedge clk);
    pulse_reset();
    check(cs_n == 1'b1 && sck == 1'b0, "R10", {30'h0, cs_n, sck}, 32'h2, "frame aborted");
    check(init_done == 1'b0, "R10", 32'(init_done), 0, "mode left");
    stray = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (rsp_valid) stray = 1'b1;
    end
    check(stray == 1'b0, "R10", 32'(stray), 0, "no response after abort");
    run_read(1, 1'b0, 3, 1, 8'h6B, 32'h0000_0A0B, "R10");

    // R11 lane enables over all frames
    check(oe_bad == 0, "R11", 32'(oe_bad), 0, "io_oe per phase");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule